// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core with Post-Increment Load

This block is a small 32-bit processor that completes one instruction on every rising clock edge. It holds its own program counter, a word-organised instruction store, a word-organised data store, a 32-entry register file, an arithmetic unit and a two-level decoder. The first level turns the opcode into datapath steering bits. The second level picks the arithmetic function.

The instruction set covers register-to-register add, subtract, and, or, signed set-less-than, a left shift by a constant, jump through a register, word load and store, branch on equal, and load of an upper immediate. It also has a load that bumps its index register. That instruction reads the word at index plus offset into one register and, in the same cycle, writes the index plus one back into the index register. The register file therefore has a second write port.

A testbench or a boot agent fills both stores through a preload port while reset is held. After reset is released, the core starts fetching at address zero. Debug outputs show the program counter and every register commit on each write port.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, and for the two clock edges that synchronise its release, the PC reads 0 and neither debug write strobe is asserted.
- R2: R-format (opcode 0) with funct 0x20/0x22/0x24/0x25/0x2A writes rs+rt, rs-rt, rs&rt, rs|rt or signed (rs<rt ? 1 : 0) into register rd (bits 15:11). Source fields are rs in bits 25:21 and rt in bits 20:16.
- R3: Funct 0x00 under opcode 0 writes rt shifted left by the shamt field (bits 10:6) into rd.
- R4: Opcode 0x0F writes the 16-bit immediate into the upper half of rt and zero into the lower half.
- R5: Opcode 0x23 loads the word at rs + sign-extended immediate into rt. Opcode 0x2B stores rt to that address. Both stores use byte-address bits [N:2] as the word index.
- R6: Opcode 0x30 writes the word at rt + sign-extended immediate into rs. In the same clock edge it writes rt+1 into rt through the second write port.
- R7: When opcode 0x30 names the same register as both rs and rt, that register receives the loaded word and no increment is committed.
- R8: Register 0 reads as zero, and writes to it from either port are discarded and not reported.
- R9: Opcode 0x04 branches to PC+4 + (sign-extended immediate << 2) when rs equals rt; otherwise the PC advances by 4.
- R10: Funct 0x08 under opcode 0 loads the PC from rs and writes no register.
- R11: Every other instruction advances the PC by exactly 4, one instruction per clock.
- R12: With `pre_we` high, `pre_data` is written at word index `pre_addr` into the instruction store (`pre_sel`=0) or the data store (`pre_sel`=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pre_we | input | 1 | Preload write strobe |
| pre_sel | input | 1 | Preload target: 0 instruction store, 1 data store |
| pre_addr | input | PA_W (6) | Preload word index |
| pre_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | Primary register write commits this cycle |
| dbg_wr_reg | output | 5 | Primary write destination |
| dbg_wr_data | output | 32 | Primary write value |
| dbg_inc_en | output | 1 | Index-increment write commits this cycle |
| dbg_inc_reg | output | 5 | Increment destination |
| dbg_inc_data | output | 32 | Increment value |

## Verification
A register result shows on the debug write outputs in the same cycle its instruction is at `dbg_pc`, and is committed at the next rising edge. The program counter of the following instruction appears one edge later. The reset synchroniser adds two idle cycles at start-up. For these reasons the bench does not count absolute cycles. At each falling edge it compares each new PC value and each reported write, in order, against queues of expected items, so only ordering and content matter. A skipped instruction or a wrong branch target shows up either as an out-of-order item or as a leftover item.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_LINC  = 6'h30;

  localparam logic [5:0] FN_SLLV  = 6'h00;
  localparam logic [5:0] FN_JR    = 6'h08;
  localparam logic [5:0] FN_ADDV  = 6'h20;
  localparam logic [5:0] FN_SUBV  = 6'h22;
  localparam logic [5:0] FN_ANDV  = 6'h24;
  localparam logic [5:0] FN_ORV   = 6'h25;
  localparam logic [5:0] FN_SLTV  = 6'h2A;

  typedef enum logic [1:0] {
    DST_RT = 2'd0,
    DST_RD = 2'd1,
    DST_RS = 2'd2
  } dst_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4,
    ALU_SLL = 3'd5,
    ALU_LUI = 3'd6
  } alu_fn_e;

  typedef struct packed {
    dst_e       dst;
    logic       alu_src;
    logic       mem_to_reg;
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       branch;
    logic       jump_reg;
    logic       post_inc;
    logic [1:0] alu_op;
  } ctrl_t;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_fn_e    alu_fn
);

  // main control
  always_comb begin
    ctrl = '{dst: DST_RT, alu_src: 1'b0, mem_to_reg: 1'b0, reg_write: 1'b0,
             mem_read: 1'b0, mem_write: 1'b0, branch: 1'b0, jump_reg: 1'b0,
             post_inc: 1'b0, alu_op: 2'b00};
    unique case (op)
      OP_RTYPE: begin
        case (funct)
          FN_JR: ctrl.jump_reg = 1'b1;
          FN_ADDV, FN_SUBV, FN_ANDV, FN_ORV, FN_SLTV, FN_SLLV: begin
            ctrl.dst       = DST_RD;
            ctrl.reg_write = 1'b1;
            ctrl.alu_op    = 2'b10;
          end
          default: ;
        endcase
      end
      OP_LW: begin
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.mem_read   = 1'b1;
      end
      OP_LINC: begin
        ctrl.dst        = DST_RS;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.mem_read   = 1'b1;
        ctrl.post_inc   = 1'b1;
      end
      OP_SW: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = 2'b01;
      end
      OP_LUI: begin
        ctrl.alu_src   = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.alu_op    = 2'b11;
      end
      default: ;
    endcase
  end

  // ALU control
  always_comb begin
    alu_fn = ALU_ADD;
    case (ctrl.alu_op)
      2'b00: alu_fn = ALU_ADD;
      2'b01: alu_fn = ALU_SUB;
      2'b11: alu_fn = ALU_LUI;
      default: begin
        case (funct)
          FN_SUBV: alu_fn = ALU_SUB;
          FN_ANDV: alu_fn = ALU_AND;
          FN_ORV:  alu_fn = ALU_OR;
          FN_SLTV: alu_fn = ALU_SLT;
          FN_SLLV: alu_fn = ALU_SLL;
          default: alu_fn = ALU_ADD;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [4:0]      shamt,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] res,
  output logic            zero
);

  always_comb begin
    case (fn)
      ALU_ADD: res = a + b;
      ALU_SUB: res = a - b;
      ALU_AND: res = a & b;
      ALU_OR:  res = a | b;
      ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: res = b << shamt;
      ALU_LUI: res = {b[XLEN-17:0], 16'h0000};
      default: res = '0;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] ra_a,
  input  logic [$clog2(NREG)-1:0] ra_b,
  output logic [XLEN-1:0]         rd_a,
  output logic [XLEN-1:0]         rd_b,
  // port A wins over port B on a shared destination
  input  logic                    we_a,
  input  logic [$clog2(NREG)-1:0] wa_a,
  input  logic [XLEN-1:0]         wd_a,
  input  logic                    we_b,
  input  logic [$clog2(NREG)-1:0] wa_b,
  input  logic [XLEN-1:0]         wd_b
);

  localparam int RW = $clog2(NREG);

  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar gi = 1; gi < NREG; gi++) begin : g_reg
    logic            hit_a;
    logic            hit_b;
    logic            en;
    logic [XLEN-1:0] d;
    logic [XLEN-1:0] q;

    always_comb begin
      hit_a = we_a && (wa_a == RW'(gi));
      hit_b = we_b && (wa_b == RW'(gi));
      en    = hit_a || hit_b;
      d     = hit_a ? wd_a : wd_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs[gi] = q;
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

endmodule

// File: rtl/mc_wmem.sv
module mc_wmem #(
  parameter int XLEN  = 32,
  parameter int WORDS = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [XLEN-1:0]          rdata
);

  logic [XLEN-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IA_W       = $clog2(IMEM_WORDS),
  localparam int DA_W       = $clog2(DMEM_WORDS),
  localparam int PA_W       = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_we,
  input  logic            pre_sel,
  input  logic [PA_W-1:0] pre_addr,
  input  logic [31:0]     pre_data,
  output logic [31:0]     dbg_pc,
  output logic            dbg_wr_en,
  output logic [4:0]      dbg_wr_reg,
  output logic [31:0]     dbg_wr_data,
  output logic            dbg_inc_en,
  output logic [4:0]      dbg_inc_reg,
  output logic [31:0]     dbg_inc_data
);

  localparam int XLEN = 32;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  // fetch
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] instr;

  mc_wmem #(.XLEN(XLEN), .WORDS(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (pre_we && !pre_sel),
    .waddr (pre_addr[IA_W-1:0]),
    .wdata (pre_data),
    .raddr (pc_q[IA_W+1:2]),
    .rdata (instr)
  );

  logic [5:0]  f_op, f_funct;
  logic [4:0]  f_rs, f_rt, f_rd, f_sh;
  logic [15:0] f_imm;

  assign f_op    = instr[31:26];
  assign f_rs    = instr[25:21];
  assign f_rt    = instr[20:16];
  assign f_rd    = instr[15:11];
  assign f_sh    = instr[10:6];
  assign f_funct = instr[5:0];
  assign f_imm   = instr[15:0];

  // decode
  ctrl_t   ctrl;
  alu_fn_e alu_fn;

  mc_decode u_dec (
    .op     (f_op),
    .funct  (f_funct),
    .ctrl   (ctrl),
    .alu_fn (alu_fn)
  );

  // register read
  logic [XLEN-1:0] rs_val, rt_val;
  logic            wr_a_en, wr_b_en;
  logic [4:0]      wr_a_reg;
  logic [XLEN-1:0] wr_a_data, wr_b_data;

  mc_regfile #(.XLEN(XLEN), .NREG(32)) u_rf (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ra_a  (f_rs),
    .ra_b  (f_rt),
    .rd_a  (rs_val),
    .rd_b  (rt_val),
    .we_a  (wr_a_en),
    .wa_a  (wr_a_reg),
    .wd_a  (wr_a_data),
    .we_b  (wr_b_en),
    .wa_b  (f_rt),
    .wd_b  (wr_b_data)
  );

  // execute
  logic [XLEN-1:0] imm_sx, alu_a, alu_b, alu_res;
  logic            alu_zero;

  assign imm_sx = {{(XLEN-16){f_imm[15]}}, f_imm};
  assign alu_a  = ctrl.post_inc ? rt_val : rs_val;
  assign alu_b  = ctrl.alu_src  ? imm_sx : rt_val;

  mc_alu #(.XLEN(XLEN)) u_alu (
    .a     (alu_a),
    .b     (alu_b),
    .shamt (f_sh),
    .fn    (alu_fn),
    .res   (alu_res),
    .zero  (alu_zero)
  );

  // data store: preload path has the port while pre_we is high
  logic            dm_we;
  logic [DA_W-1:0] dm_waddr;
  logic [XLEN-1:0] dm_wdata, dm_rdata;

  always_comb begin
    if (pre_we) begin
      dm_we    = pre_sel;
      dm_waddr = pre_addr[DA_W-1:0];
      dm_wdata = pre_data;
    end else begin
      dm_we    = ctrl.mem_write && rst_n_s;
      dm_waddr = alu_res[DA_W+1:2];
      dm_wdata = rt_val;
    end
  end

  mc_wmem #(.XLEN(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_res[DA_W+1:2]),
    .rdata (dm_rdata)
  );

  // write back
  always_comb begin
    case (ctrl.dst)
      DST_RD:  wr_a_reg = f_rd;
      DST_RS:  wr_a_reg = f_rs;
      default: wr_a_reg = f_rt;
    endcase
    wr_a_data = ctrl.mem_to_reg ? (ctrl.mem_read ? dm_rdata : '0) : alu_res;
    wr_a_en   = ctrl.reg_write && rst_n_s && (wr_a_reg != 5'd0);
    wr_b_data = rt_val + 1'b1;
    wr_b_en   = ctrl.post_inc && rst_n_s && (f_rt != 5'd0) && (f_rt != wr_a_reg);
  end

  // next PC
  logic [XLEN-1:0] pc_plus4, br_target;
  logic            pc_en;

  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign pc_en     = 1'b1;

  always_comb begin
    if (ctrl.jump_reg)                pc_d = rs_val;
    else if (ctrl.branch && alu_zero) pc_d = br_target;
    else                              pc_d = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign dbg_pc       = pc_q;
  assign dbg_wr_en    = wr_a_en;
  assign dbg_wr_reg   = wr_a_reg;
  assign dbg_wr_data  = wr_a_data;
  assign dbg_inc_en   = wr_b_en;
  assign dbg_inc_reg  = f_rt;
  assign dbg_inc_data = wr_b_data;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rst_n_s,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] dbg_pc,
  input logic        dbg_wr_en,
  input logic [4:0]  dbg_wr_reg,
  input logic        dbg_inc_en,
  input logic [4:0]  dbg_inc_reg
);

  logic        is_jr, is_beq, is_seq;
  logic [31:0] br_off;

  assign is_jr  = (instr[31:26] == OP_RTYPE) && (instr[5:0] == FN_JR);
  assign is_beq = (instr[31:26] == OP_BEQ);
  assign is_seq = !is_jr && !is_beq;
  assign br_off = {{14{instr[15]}}, instr[15:0], 2'b00};

  assert_quiet_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_n_s |-> (!dbg_wr_en && !dbg_inc_en));

  assert_inc_from_load_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    dbg_inc_en |-> (instr[31:26] == OP_LINC) && (dbg_inc_reg == instr[20:16]) && dbg_wr_en);

  assert_same_reg_no_inc_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    dbg_inc_en |-> (dbg_inc_reg != dbg_wr_reg));

  assert_zero_reg_silent_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!dbg_wr_en || dbg_wr_reg != 5'd0) && (!dbg_inc_en || dbg_inc_reg != 5'd0));

  assert_beq_target_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (is_beq && rs_val == rt_val) |=> dbg_pc == $past(dbg_pc) + 32'd4 + $past(br_off));

  assert_jr_target_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    is_jr |=> dbg_pc == $past(rs_val));

  assert_pc_step_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (is_seq || (is_beq && rs_val != rt_val)) |=> dbg_pc == $past(dbg_pc) + 32'd4);

endmodule

bind mc_core mc_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_n_s     (rst_n_s),
  .instr       (instr),
  .rs_val      (rs_val),
  .rt_val      (rt_val),
  .dbg_pc      (dbg_pc),
  .dbg_wr_en   (dbg_wr_en),
  .dbg_wr_reg  (dbg_wr_reg),
  .dbg_inc_en  (dbg_inc_en),
  .dbg_inc_reg (dbg_inc_reg)
);

// File: tb/mc_core_test.sv
module mc_core_test;

  logic        clk;
  logic        rst_n;
  logic        pre_we;
  logic        pre_sel;
  logic [5:0]  pre_addr;
  logic [31:0] pre_data;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_reg;
  logic [31:0] dbg_wr_data;
  logic        dbg_inc_en;
  logic [4:0]  dbg_inc_reg;
  logic [31:0] dbg_inc_data;

  mc_core uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pre_we       (pre_we),
    .pre_sel      (pre_sel),
    .pre_addr     (pre_addr),
    .pre_data     (pre_data),
    .dbg_pc       (dbg_pc),
    .dbg_wr_en    (dbg_wr_en),
    .dbg_wr_reg   (dbg_wr_reg),
    .dbg_wr_data  (dbg_wr_data),
    .dbg_inc_en   (dbg_inc_en),
    .dbg_inc_reg  (dbg_inc_reg),
    .dbg_inc_data (dbg_inc_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  typedef struct {
    logic [4:0]  r;
    logic [31:0] v;
    string       req;
  } wr_item_t;

  wr_item_t    wr_q[$];
  wr_item_t    inc_q[$];
  logic [31:0] pc_exp_q[$];
  logic [31:0] prev_pc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                        logic [4:0] sh, logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic expect_wr(input logic [4:0] r, input logic [31:0] v, input string req);
    wr_item_t it;
    it.r = r; it.v = v; it.req = req;
    wr_q.push_back(it);
  endtask

  task automatic expect_inc(input logic [4:0] r, input logic [31:0] v, input string req);
    wr_item_t it;
    it.r = r; it.v = v; it.req = req;
    inc_q.push_back(it);
  endtask

  task automatic preload(input bit sel, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    pre_we   = 1'b1;
    pre_sel  = sel;
    pre_addr = a;
    pre_data = d;
  endtask

  // monitor: pops expected items as the design reports them
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (dbg_pc != prev_pc) begin
        if (pc_exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected pc", dbg_pc, 32'hx);
        end else begin
          logic [31:0] e;
          e = pc_exp_q.pop_front();
          check(dbg_pc == e, "R9/R10/R11", "pc sequence", dbg_pc, e);
        end
        prev_pc = dbg_pc;
      end
      if (dbg_wr_en) begin
        if (wr_q.size() == 0) begin
          check(1'b0, "R8", "unexpected write", {27'd0, dbg_wr_reg}, 32'hx);
        end else begin
          wr_item_t it;
          it = wr_q.pop_front();
          check(dbg_wr_reg == it.r, it.req, "write reg", {27'd0, dbg_wr_reg}, {27'd0, it.r});
          check(dbg_wr_data == it.v, it.req, "write data", dbg_wr_data, it.v);
        end
      end
      if (dbg_inc_en) begin
        if (inc_q.size() == 0) begin
          check(1'b0, "R7", "unexpected increment", {27'd0, dbg_inc_reg}, 32'hx);
        end else begin
          wr_item_t it;
          it = inc_q.pop_front();
          check(dbg_inc_reg == it.r, it.req, "inc reg", {27'd0, dbg_inc_reg}, {27'd0, it.r});
          check(dbg_inc_data == it.v, it.req, "inc data", dbg_inc_data, it.v);
        end
      end
    end
  end

  logic [31:0] prog [27];

  initial begin
    rst_n    = 1'b0;
    pre_we   = 1'b0;
    pre_sel  = 1'b0;
    pre_addr = '0;
    pre_data = '0;
    prev_pc  = '0;

    prog[0]  = enc_i(6'h0F, 5'd0, 5'd1, 16'h1234);       // lui r1
    prog[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd0);          // lw r2, 0(r0)
    prog[2]  = enc_i(6'h23, 5'd0, 5'd3, 16'd4);          // lw r3, 4(r0)
    prog[3]  = enc_r(5'd2, 5'd3, 5'd4, 5'd0, 6'h20);     // add
    prog[4]  = enc_r(5'd2, 5'd3, 5'd5, 5'd0, 6'h22);     // sub
    prog[5]  = enc_r(5'd2, 5'd3, 5'd6, 5'd0, 6'h24);     // and
    prog[6]  = enc_r(5'd2, 5'd3, 5'd7, 5'd0, 6'h25);     // or
    prog[7]  = enc_r(5'd5, 5'd2, 5'd8, 5'd0, 6'h2A);     // slt -2 < 5
    prog[8]  = enc_r(5'd2, 5'd5, 5'd9, 5'd0, 6'h2A);     // slt 5 < -2
    prog[9]  = enc_r(5'd0, 5'd3, 5'd10, 5'd4, 6'h00);    // sll r3 by 4
    prog[10] = enc_i(6'h2B, 5'd0, 5'd4, 16'd24);         // sw r4 -> word 6
    prog[11] = enc_i(6'h23, 5'd0, 5'd11, 16'd24);        // lw r11 <- word 6
    prog[12] = enc_r(5'd2, 5'd3, 5'd0, 5'd0, 6'h20);     // add into r0
    prog[13] = enc_r(5'd0, 5'd2, 5'd12, 5'd0, 6'h20);    // r12 = r0 + r2
    prog[14] = enc_i(6'h30, 5'd13, 5'd2, 16'hFFFF);      // post-inc load, offset -1
    prog[15] = enc_i(6'h30, 5'd14, 5'd14, 16'd16);       // same register
    prog[16] = enc_r(5'd14, 5'd0, 5'd15, 5'd0, 6'h20);   // r15 = r14
    prog[17] = enc_i(6'h30, 5'd16, 5'd0, 16'd0);         // index r0
    prog[18] = enc_i(6'h04, 5'd2, 5'd3, 16'd5);          // beq not taken
    prog[19] = enc_i(6'h04, 5'd2, 5'd2, 16'd2);          // beq taken -> word 22
    prog[20] = enc_i(6'h0F, 5'd0, 5'd17, 16'hDEAD);      // skipped
    prog[21] = enc_i(6'h0F, 5'd0, 5'd17, 16'hBEEF);      // skipped
    prog[22] = enc_i(6'h23, 5'd0, 5'd18, 16'd20);        // r18 = 100
    prog[23] = enc_r(5'd18, 5'd0, 5'd0, 5'd0, 6'h08);    // jr r18
    prog[24] = enc_i(6'h0F, 5'd0, 5'd19, 16'hDEAD);      // skipped
    prog[25] = enc_i(6'h0F, 5'd0, 5'd19, 16'h0001);      // lui r19
    prog[26] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);       // branch to self

    repeat (2) @(negedge clk);
    check(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
    check(!dbg_wr_en && !dbg_inc_en, "R1", "write strobes in reset",
          {30'd0, dbg_wr_en, dbg_inc_en}, 32'd0);

    // R12: preload both stores while reset is held
    for (int i = 0; i < 27; i++) preload(1'b0, 6'(i), prog[i]);
    preload(1'b1, 6'd0, 32'd5);
    preload(1'b1, 6'd1, 32'd7);
    preload(1'b1, 6'd4, 32'hAAAA5555);
    preload(1'b1, 6'd5, 32'd100);
    @(negedge clk);
    pre_we = 1'b0;
    @(negedge clk);
    check(dbg_pc == 32'd0, "R1", "pc after preload", dbg_pc, 32'd0);
    check(!dbg_wr_en && !dbg_inc_en, "R1", "no write after preload",
          {30'd0, dbg_wr_en, dbg_inc_en}, 32'd0);

    // expected PC stream: words 1..19, then 22, 23, 25, 26 (byte addr = 4*word)
    for (int w = 1; w <= 19; w++) pc_exp_q.push_back(32'(w * 4));
    pc_exp_q.push_back(32'd88);
    pc_exp_q.push_back(32'd92);
    pc_exp_q.push_back(32'd100);
    pc_exp_q.push_back(32'd104);

    expect_wr(5'd1,  32'h1234_0000, "R4");
    expect_wr(5'd2,  32'd5, "R5 R12");
    expect_wr(5'd3,  32'd7, "R5");
    expect_wr(5'd4,  32'd5 + 32'd7, "R2 add");
    expect_wr(5'd5,  32'd5 - 32'd7, "R2 sub");
    expect_wr(5'd6,  32'd5 & 32'd7, "R2 and");
    expect_wr(5'd7,  32'd5 | 32'd7, "R2 or");
    expect_wr(5'd8,  32'd1, "R2 slt signed");
    expect_wr(5'd9,  32'd0, "R2 slt signed");
    expect_wr(5'd10, 32'd7 << 4, "R3");
    expect_wr(5'd11, 32'd12, "R5 store then load");
    expect_wr(5'd12, 32'd5, "R8 r0 reads zero");
    expect_wr(5'd13, 32'd7, "R6 load part");
    expect_inc(5'd2, 32'd6, "R6 increment part");
    expect_wr(5'd14, 32'hAAAA5555, "R7 load wins");
    expect_wr(5'd15, 32'hAAAA5555, "R7 no increment");
    expect_wr(5'd16, 32'd5, "R8 r0 index not bumped");
    expect_wr(5'd18, 32'd100, "R9 taken skip");
    expect_wr(5'd19, 32'h0001_0000, "R10 jr target");

    mon_on = 1'b1;
    rst_n  = 1'b1;
    repeat (60) @(negedge clk);

    check(pc_exp_q.size() == 0, "R11", "pc items left", 32'(pc_exp_q.size()), 32'd0);
    check(wr_q.size() == 0, "R2", "write items left", 32'(wr_q.size()), 32'd0);
    check(inc_q.size() == 0, "R6", "inc items left", 32'(inc_q.size()), 32'd0);
    check(dbg_pc == 32'd104, "R9", "backward branch holds pc", dbg_pc, 32'd104);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 5000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule